// File: doc/BRIEF.md
# Core/Bus Clock Ratio Controller

This block generates two clock enables from a single reference clock that runs at six times the external bus rate. The bus-clock enable marks each bus cycle. The core-clock enable marks each core cycle, and its rate relative to the bus follows a ratio held in a small configuration register. The surrounding logic gates its flops with these enables.

The reset ratio comes from a strap input. Software can lower the core rate to match the bus when it wants to save power, and can later restore a faster ratio. A half-speed bit drops the core to half the bus rate. While an external bus transfer is in progress, the core temporarily returns to the programmed ratio. A new setting, or a change of transfer state, takes effect only at a bus-cycle boundary, so a core cycle is never cut short or doubled.

Top module: `ckratio_ctrl`

## Requirements
- R1: While reset is asserted, the ratio field (read bits [1:0]) loads 1 if `strap_hi_i` is 0 and 3 if it is 1. The half-speed bit (read bit 2) loads 0.
- R2: Ratio code 0 gives one core pulse per bus period (1:1), code 1 gives two (2:1) and code 3 gives three (3:1). The pulses are evenly spaced every 6, 3 or 2 reference cycles.
- R3: `bus_en_o` is high for one reference cycle in every 6. Its first pulse comes 5 rising edges after reset is released.
- R4: A write whose bits [1:0] equal the reserved code 2 leaves the ratio field unchanged. Bit 2 of that write is still stored. The ratio field never reads 2.
- R5: Read bits [7:3] are always 0, and writing them has no effect.
- R6: With bit 2 set and `xfer_act_i` low, the core pulses once every 12 reference cycles, on every second bus pulse.
- R7: With bit 2 set and `xfer_act_i` high, the core runs at the programmed ratio. It drops back to half the bus rate once `xfer_act_i` falls.
- R8: A change of ratio, mode or transfer state takes effect at the next bus boundary. Core pulses are never on two adjacent cycles, and there are never more than 3 in one bus period.
- R9: A register write is visible on `reg_rdata_o` in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, 6x bus rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_hi_i | input | 1 | Power-up ratio select: 0 gives 2:1, 1 gives 3:1 |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data: {5'b0, half, ratio[1:0]} |
| xfer_act_i | input | 1 | External bus transfer in progress |
| bus_en_o | output | 1 | Bus-clock enable |
| core_en_o | output | 1 | Core-clock enable |

## Verification
A register write is due on the read port one rising edge after the strobe. Its effect on the enables is due only after the next edge on which `bus_en_o` is high, which is up to 6 edges later. A change of `xfer_act_i` takes effect at that same boundary. The bench model applies these delays cycle by cycle, and every output is compared at the falling edge, away from the update edge. The pulse-count checks open their 24-cycle window 12 cycles after each stimulus, so a full bus period has already passed.

// File: rtl/ckr_pkg.sv
package ckr_pkg;
  typedef enum logic [1:0] {
    RATIO_1   = 2'd0,
    RATIO_2   = 2'd1,
    RATIO_RSV = 2'd2,
    RATIO_3   = 2'd3
  } ratio_e;

  typedef struct packed {
    logic   half;
    ratio_e ratio;
  } cfg_t;
endpackage

// File: rtl/ckr_phase_gen.sv
module ckr_phase_gen #(
  parameter int BUS_DIV = 6,
  localparam int SW = $clog2(BUS_DIV)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [SW-1:0] sub_o,
  output logic          odd_o,
  output logic          bus_tick_o
);
  logic [SW-1:0] sub_q;
  logic          odd_q;

  assign bus_tick_o = (sub_q == SW'(BUS_DIV-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      odd_q <= 1'b0;
    end else if (bus_tick_o) begin
      sub_q <= '0;
      odd_q <= ~odd_q;
    end else begin
      sub_q <= sub_q + SW'(1);
    end
  end

  assign sub_o = sub_q;
  assign odd_o = odd_q;
endmodule

// File: rtl/ckr_cfg_reg.sv
module ckr_cfg_reg
  import ckr_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strap_hi_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output cfg_t             cfg_o,
  output logic [REG_W-1:0] rdata_o
);
  cfg_t   cfg_q;
  ratio_e wr_ratio;
  logic   unused_wbits;

  assign wr_ratio     = ratio_e'(wdata_i[1:0]);
  assign unused_wbits = ^wdata_i[REG_W-1:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.half  <= 1'b0;
      cfg_q.ratio <= strap_hi_i ? RATIO_3 : RATIO_2;
    end else if (we_i) begin
      cfg_q.half <= wdata_i[2];
      if (wr_ratio != RATIO_RSV) cfg_q.ratio <= wr_ratio;
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {{(REG_W-3){1'b0}}, cfg_q.half, cfg_q.ratio};
endmodule

// File: rtl/ckr_pulse_sel.sv
module ckr_pulse_sel
  import ckr_pkg::*;
#(
  parameter int BUS_DIV = 6,
  localparam int SW = $clog2(BUS_DIV)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strap_hi_i,
  input  cfg_t          cfg_i,
  input  logic          xfer_i,
  input  logic [SW-1:0] sub_i,
  input  logic          odd_i,
  input  logic          bus_tick_i,
  output logic          core_en_o
);
  cfg_t       act_q;
  logic [2:0] hit;

  // one candidate pulse train per core:bus multiple 1..3
  for (genvar gi = 0; gi < 3; gi++) begin : g_div
    localparam int D = BUS_DIV / (gi + 1);
    assign hit[gi] = ((int'(sub_i) % D) == D - 1);
  end

  // settings apply only on a bus boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q.half  <= 1'b0;
      act_q.ratio <= strap_hi_i ? RATIO_3 : RATIO_2;
    end else if (bus_tick_i) begin
      act_q.half  <= cfg_i.half & ~xfer_i;
      act_q.ratio <= cfg_i.ratio;
    end
  end

  always_comb begin
    if (act_q.half) begin
      core_en_o = bus_tick_i & odd_i;
    end else begin
      unique case (act_q.ratio)
        RATIO_1: core_en_o = hit[0];
        RATIO_2: core_en_o = hit[1];
        default: core_en_o = hit[2];
      endcase
    end
  end
endmodule

// File: rtl/ckratio_ctrl.sv
module ckratio_ctrl
  import ckr_pkg::*;
#(
  parameter int BUS_DIV = 6,
  parameter int REG_W   = 8,
  localparam int SW = $clog2(BUS_DIV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strap_hi_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             xfer_act_i,
  output logic             bus_en_o,
  output logic             core_en_o
);
  cfg_t          cfg;
  logic [SW-1:0] sub;
  logic          odd;
  logic          bus_tick;

  ckr_phase_gen #(.BUS_DIV(BUS_DIV)) u_phase (
    .clk_i, .rst_ni, .sub_o(sub), .odd_o(odd), .bus_tick_o(bus_tick)
  );

  ckr_cfg_reg #(.REG_W(REG_W)) u_cfg (
    .clk_i, .rst_ni, .strap_hi_i, .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .cfg_o(cfg), .rdata_o(reg_rdata_o)
  );

  ckr_pulse_sel #(.BUS_DIV(BUS_DIV)) u_sel (
    .clk_i, .rst_ni, .strap_hi_i, .cfg_i(cfg), .xfer_i(xfer_act_i),
    .sub_i(sub), .odd_i(odd), .bus_tick_i(bus_tick), .core_en_o
  );

  assign bus_en_o = bus_tick;
endmodule

// File: rtl/ckr_chk.sv
module ckr_chk #(
  parameter int BUS_DIV = 6,
  parameter int REG_W   = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             bus_en_o,
  input logic             core_en_o
);
  int gap_q;
  int core_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q      <= 0;
      core_cnt_q <= 0;
    end else if (bus_en_o) begin
      gap_q      <= 0;
      core_cnt_q <= 0;
    end else begin
      gap_q      <= gap_q + 1;
      core_cnt_q <= core_cnt_q + int'(core_en_o);
    end
  end

  assert_bus_period_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |-> gap_q == BUS_DIV - 1);
  assert_bus_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |=> !bus_en_o);
  assert_core_no_double_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_en_o |=> !core_en_o);
  assert_core_max_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |-> (core_cnt_q + int'(core_en_o)) <= 3);
  assert_rsv_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[REG_W-1:3] == '0);
  assert_rsv_code_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_wdata_i[1:0] == 2'd2) |=> reg_rdata_o[1:0] == $past(reg_rdata_o[1:0]));
  assert_never_rsv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[1:0] != 2'd2);
  assert_write_seen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_wdata_i[1:0] != 2'd2) |=> reg_rdata_o[2:0] == $past(reg_wdata_i[2:0]));
endmodule

bind ckratio_ctrl ckr_chk #(.BUS_DIV(BUS_DIV), .REG_W(REG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o), .bus_en_o(bus_en_o), .core_en_o(core_en_o)
);

// File: tb/sim_ckratio_ctrl.sv
`timescale 1ns/1ps
module sim_ckratio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       xfer = 1'b0;
  logic       bus_en, core_en;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int n = 0;
  int m_ratio = 1, m_half = 0, a_ratio = 1, a_half = 0;

  always #4 clk = ~clk;

  ckratio_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .strap_hi_i(strap), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .xfer_act_i(xfer),
    .bus_en_o(bus_en), .core_en_o(core_en)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n = 0;
      m_ratio = strap ? 3 : 1;
      m_half  = 0;
      a_ratio = m_ratio;
      a_half  = 0;
    end else begin
      if (n % 6 == 5) begin
        a_ratio = m_ratio;
        a_half  = (m_half != 0 && !xfer) ? 1 : 0;
      end
      if (we) begin
        m_half = int'(wdata[2]);
        if (wdata[1:0] != 2'd2) m_ratio = int'(wdata[1:0]);
      end
      n++;
    end
  end

  function automatic bit exp_core();
    int k, d;
    if (a_half != 0) return (n % 6 == 5) && ((n / 6) % 2 == 1);
    k = (a_ratio == 0) ? 1 : (a_ratio == 1) ? 2 : 3;
    d = 6 / k;
    return (n % d) == d - 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 bus_en", int'(bus_en), int'(n % 6 == 5));
      check("R8 core_en", int'(core_en), int'(exp_core()));
      check("R9 rdata", int'(rdata), (m_half << 2) | m_ratio);
    end
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic count_pulses(output int nb, output int nc);
    nb = 0; nc = 0;
    repeat (12) @(negedge clk);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      nb += int'(bus_en);
      nc += int'(core_en);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    strap = s;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int nb, nc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset strap low", int'(rdata), 1);

    count_pulses(nb, nc);
    check("R3 bus pulses in 24", nb, 4);
    check("R2 default 2:1", nc, 8);

    wr(8'h00);
    check("R9 readback 0", int'(rdata), 0);
    count_pulses(nb, nc);
    check("R2 ratio 1:1", nc, 4);

    wr(8'h03);
    count_pulses(nb, nc);
    check("R2 ratio 3:1", nc, 12);

    wr(8'h02);
    check("R4 reserved code ignored", int'(rdata[1:0]), 3);
    count_pulses(nb, nc);
    check("R4 rate kept 3:1", nc, 12);

    wr(8'hFD);
    check("R5 reserved bits zero", int'(rdata), 8'h05);
    count_pulses(nb, nc);
    check("R6 half speed", nc, 2);

    wr(8'h06);
    check("R4 bit2 stored with code 2", int'(rdata), 8'h05);

    xfer = 1'b1;
    count_pulses(nb, nc);
    check("R7 transfer restores 2:1", nc, 8);
    wr(8'h07);
    count_pulses(nb, nc);
    check("R7 transfer restores 3:1", nc, 12);
    xfer = 1'b0;
    count_pulses(nb, nc);
    check("R7 back to half after transfer", nc, 2);

    wr(8'h01);
    count_pulses(nb, nc);
    check("R8 half cleared, 2:1", nc, 8);

    do_reset(1'b1);
    check("R1 reset strap high", int'(rdata), 3);
    count_pulses(nb, nc);
    check("R1 strap high rate 3:1", nc, 12);
    check("R3 bus pulses after reset", nb, 4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule